// File: doc/BRIEF.md
# Static Screen Detection Controller

This block sits next to a display timing generator and decides when the picture has been still long enough for the panel to go into self-refresh. Each frame ends with a one-cycle vertical sync strobe. Five update sources can disturb the picture: a forced trigger, cursor moves, surface flips, overlay updates and an external manual trigger. A programmable event mask picks which of them count. The block counts frames that end with no masked event. When that count first reaches a programmed threshold, it raises a one-cycle static-screen interrupt. Software then starts the self-refresh entry.

A second output serves variable refresh rate operation. It pulses right after any masked event and never waits for the frame count. Software loads the mask and the threshold through simple write strobes. Both values are shadowed and move into the active set at the next vertical sync. A write to the threshold above the 8-bit range is clamped. Software picks the threshold as floor(30000 / frame_time_us) + 1, so the still interval lasts at least 30 ms whatever the refresh rate. A compression-enable input adds the bits used by the frame-buffer compressor to the mask. A parameter selects the newer variant, in which the overlay bit cannot be set.

Top module: `static_idle_detect`

## Requirements
- R1: The mask bit positions are: bit 0 force, bit 1 cursor, bit 7 surface, bit 8 overlay, bit 11 manual trigger. An event whose active mask bit is 1 makes `refresh_trig_o` high in the cycle after the event. An event whose mask bit is 0 does not.
- R2: The refresh trigger pulses on every masked event, whatever the state of the static frame count, including while the count is running and after the interrupt has fired.
- R3: A frame with a masked event in it (the vsync cycle included) resets the clean-frame count to zero at that frame's vsync. `static_irq_o` is high for the cycle after the vsync that ends the threshold-th consecutive clean frame.
- R4: The interrupt is a single-cycle pulse. After it fires, no further interrupt occurs until a masked event or a configuration reload restarts detection.
- R5: A threshold write above 255 loads 255, not the low 8 bits of the value.
- R6: After reset both outputs are low, the active mask is 0, and the active threshold is 2 frames.
- R7: An active threshold of 0 never produces an interrupt.
- R8: With an all-zero effective mask, no event breaks the static condition and no refresh trigger is produced.
- R9: Mask and threshold writes take effect at the next vsync. That vsync resets the clean-frame count to zero and produces no interrupt.
- R10: In the newer variant (MODERN=1, the default), bit 8 of a mask write is stored as 0, so overlay events have no effect.
- R11: While `fbc_en_i` is high, bits 2 and 7 are added to the effective mask, so surface events count even when the programmed mask is 0.
- R12: Thresholds from the 30 ms rule (2 frames at 60 Hz, 5 frames at 144 Hz) make the interrupt fire after exactly that many clean frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | One-cycle strobe at each frame end |
| ev_force_i | input | 1 | Forced update event |
| ev_cursor_i | input | 1 | Cursor update event |
| ev_surface_i | input | 1 | Surface update event |
| ev_overlay_i | input | 1 | Overlay update event |
| ev_manual_i | input | 1 | External manual trigger event |
| fbc_en_i | input | 1 | Frame-buffer compression enabled |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 12 | Mask write data |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | 16 | Threshold write data (clamped to 255) |
| static_irq_o | output | 1 | Static-screen interrupt pulse |
| refresh_trig_o | output | 1 | Immediate refresh trigger pulse |

## Verification
The bench targets the configuration edge cases:
- A clamp that only truncated would load 44 for a write of 300.
- A reload that did not clear the count would fire early, on the reload vsync itself.
- An interrupt that was not disarmed after firing would repeat every frame.

It also checks that an event arriving in the vsync cycle itself still marks that frame as dirty. A design that got this wrong would fire one frame early. Three more cases cover the mask handling: the compression bits forcing surface events to count, the overlay bit being dropped in the newer variant, and a zero threshold keeping the interrupt silent forever.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int MASK_W      = 12;
  localparam int BIT_FORCE   = 0;
  localparam int BIT_CURSOR  = 1;
  localparam int BIT_FBC     = 2;
  localparam int BIT_SURFACE = 7;
  localparam int BIT_OVERLAY = 8;
  localparam int BIT_TRIG_A  = 11;

  typedef logic [MASK_W-1:0] evmask_t;

  typedef struct packed {
    logic force_ev;
    logic cursor;
    logic surface;
    logic overlay;
    logic manual;
  } ev_in_t;

  function automatic evmask_t compression_bits();
    evmask_t m;
    m = '0;
    m[BIT_FBC]     = 1'b1;
    m[BIT_SURFACE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sid_cfg_shadow.sv
module sid_cfg_shadow
  import sid_pkg::*;
#(
  parameter int THR_IN_W  = 16,
  parameter int CNT_W     = 8,
  parameter int MODERN    = 1,
  parameter int RESET_THR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync,
  input  logic                mask_wr,
  input  evmask_t             mask_wdata,
  input  logic                thr_wr,
  input  logic [THR_IN_W-1:0] thr_wdata,
  output evmask_t             act_mask,
  output logic [CNT_W-1:0]    act_thr,
  output logic                reload
);
  localparam int THR_MAX = (1 << CNT_W) - 1;

  evmask_t          keep_bits;
  evmask_t          pend_mask;
  logic [CNT_W-1:0] pend_thr;
  logic [CNT_W-1:0] thr_clamped;
  logic             upd_pend;

  generate
    if (MODERN != 0) begin : g_modern
      assign keep_bits = ~(evmask_t'(1) << BIT_OVERLAY);
    end else begin : g_legacy
      assign keep_bits = '1;
    end
  endgenerate

  always_comb begin
    if (thr_wdata > THR_IN_W'(THR_MAX))
      thr_clamped = CNT_W'(THR_MAX);
    else
      thr_clamped = thr_wdata[CNT_W-1:0];
  end

  assign reload = vsync & upd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mask <= '0;
      pend_thr  <= CNT_W'(RESET_THR);
      upd_pend  <= 1'b0;
      act_mask  <= '0;
      act_thr   <= CNT_W'(RESET_THR);
    end else begin
      if (reload) begin
        act_mask <= pend_mask;
        act_thr  <= pend_thr;
      end
      if (mask_wr) pend_mask <= mask_wdata & keep_bits;
      if (thr_wr)  pend_thr  <= thr_clamped;
      if (mask_wr || thr_wr) upd_pend <= 1'b1;
      else if (vsync)        upd_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sid_event_sel.sv
module sid_event_sel
  import sid_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ev_in_t  ev,
  input  logic    fbc_en,
  input  evmask_t act_mask,
  output logic    hit,
  output logic    refresh_trig
);
  evmask_t evec;
  evmask_t eff_mask;

  always_comb begin
    evec              = '0;
    evec[BIT_FORCE]   = ev.force_ev;
    evec[BIT_CURSOR]  = ev.cursor;
    evec[BIT_SURFACE] = ev.surface;
    evec[BIT_OVERLAY] = ev.overlay;
    evec[BIT_TRIG_A]  = ev.manual;
    eff_mask          = act_mask | (fbc_en ? compression_bits() : '0);
    hit               = |(evec & eff_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) refresh_trig <= 1'b0;
    else     refresh_trig <= hit;
  end
endmodule

// File: rtl/sid_static_cnt.sv
module sid_static_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsync,
  input  logic             hit,
  input  logic             reload,
  input  logic [CNT_W-1:0] thr,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             dirty;
  logic             armed;

  always_comb begin
    if (&cnt) cnt_nxt = cnt;
    else      cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dirty <= 1'b0;
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (vsync) begin
        dirty <= 1'b0;
        if (reload || dirty || hit) begin
          cnt   <= '0;
          armed <= 1'b1;
        end else begin
          cnt <= cnt_nxt;
          if (armed && (thr != '0) && (cnt_nxt == thr)) begin
            irq   <= 1'b1;
            armed <= 1'b0;
          end
        end
      end else if (hit) begin
        dirty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/static_idle_detect.sv
module static_idle_detect
  import sid_pkg::*;
#(
  parameter int THR_IN_W  = 16,
  parameter int CNT_W     = 8,
  parameter int MODERN    = 1,
  parameter int RESET_THR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync_i,
  input  logic                ev_force_i,
  input  logic                ev_cursor_i,
  input  logic                ev_surface_i,
  input  logic                ev_overlay_i,
  input  logic                ev_manual_i,
  input  logic                fbc_en_i,
  input  logic                mask_wr_i,
  input  logic [11:0]         mask_wdata_i,
  input  logic                thr_wr_i,
  input  logic [THR_IN_W-1:0] thr_wdata_i,
  output logic                static_irq_o,
  output logic                refresh_trig_o
);
  evmask_t          act_mask;
  logic [CNT_W-1:0] act_thr;
  logic             cfg_reload;
  logic             ev_hit;
  ev_in_t           ev_bus;

  assign ev_bus = '{force_ev: ev_force_i, cursor: ev_cursor_i,
                    surface: ev_surface_i, overlay: ev_overlay_i,
                    manual: ev_manual_i};

  sid_cfg_shadow #(
    .THR_IN_W(THR_IN_W), .CNT_W(CNT_W), .MODERN(MODERN), .RESET_THR(RESET_THR)
  ) u_cfg (
    .clk(clk), .rst(rst), .vsync(vsync_i),
    .mask_wr(mask_wr_i), .mask_wdata(mask_wdata_i),
    .thr_wr(thr_wr_i), .thr_wdata(thr_wdata_i),
    .act_mask(act_mask), .act_thr(act_thr), .reload(cfg_reload)
  );

  sid_event_sel u_evt (
    .clk(clk), .rst(rst), .ev(ev_bus), .fbc_en(fbc_en_i),
    .act_mask(act_mask), .hit(ev_hit), .refresh_trig(refresh_trig_o)
  );

  sid_static_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .vsync(vsync_i), .hit(ev_hit),
    .reload(cfg_reload), .thr(act_thr), .irq(static_irq_o)
  );
endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
  parameter int CNT_W  = 8,
  parameter int MODERN = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             vsync_i,
  input logic             ev_force_i,
  input logic             ev_cursor_i,
  input logic             ev_surface_i,
  input logic             ev_overlay_i,
  input logic             ev_manual_i,
  input logic             cfg_reload,
  input logic [CNT_W-1:0] act_thr,
  input logic             static_irq_o,
  input logic             refresh_trig_o
);
  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    static_irq_o |=> !static_irq_o);

  a_r3_irq_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    static_irq_o |-> $past(vsync_i));

  a_r2_trig_needs_event: assert property (@(posedge clk) disable iff (rst)
    refresh_trig_o |-> $past(ev_force_i | ev_cursor_i | ev_surface_i | ev_overlay_i | ev_manual_i));

  a_r9_no_irq_on_reload: assert property (@(posedge clk) disable iff (rst)
    static_irq_o |-> !$past(cfg_reload));

  a_r7_zero_thr_silent: assert property (@(posedge clk) disable iff (rst)
    static_irq_o |-> (act_thr != '0));

  a_r10_overlay_dropped: assert property (@(posedge clk) disable iff (rst)
    ((MODERN != 0) && refresh_trig_o) |-> $past(ev_force_i | ev_cursor_i | ev_surface_i | ev_manual_i));
endmodule

bind static_idle_detect sid_checker #(.CNT_W(CNT_W), .MODERN(MODERN)) u_chk (
  .clk(clk), .rst(rst), .vsync_i(vsync_i),
  .ev_force_i(ev_force_i), .ev_cursor_i(ev_cursor_i), .ev_surface_i(ev_surface_i),
  .ev_overlay_i(ev_overlay_i), .ev_manual_i(ev_manual_i),
  .cfg_reload(cfg_reload), .act_thr(act_thr),
  .static_irq_o(static_irq_o), .refresh_trig_o(refresh_trig_o)
);

// File: tb/sim_static_idle_detect.sv
`timescale 1ns/1ps
module sim_static_idle_detect;
  localparam int MODERN = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync_i = 0, ev_force_i = 0, ev_cursor_i = 0, ev_surface_i = 0;
  logic ev_overlay_i = 0, ev_manual_i = 0, fbc_en_i = 0;
  logic mask_wr_i = 0, thr_wr_i = 0;
  logic [11:0] mask_wdata_i = '0;
  logic [15:0] thr_wdata_i = '0;
  logic static_irq_o, refresh_trig_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R6";
  bit done = 0;

  always #2 clk = ~clk;

  static_idle_detect #(.MODERN(MODERN)) u0 (
    .clk(clk), .rst(rst), .vsync_i(vsync_i),
    .ev_force_i(ev_force_i), .ev_cursor_i(ev_cursor_i), .ev_surface_i(ev_surface_i),
    .ev_overlay_i(ev_overlay_i), .ev_manual_i(ev_manual_i), .fbc_en_i(fbc_en_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .thr_wr_i(thr_wr_i), .thr_wdata_i(thr_wdata_i),
    .static_irq_o(static_irq_o), .refresh_trig_o(refresh_trig_o)
  );

  // Behavioural reference model
  int m_pm, m_pt, m_am, m_at, m_cnt;
  bit m_up, m_hit, m_arm, e_irq, e_trig;

  always @(posedge clk) begin
    int evv, emask, nc;
    bit hitnow;
    if (rst) begin
      m_pm = 0; m_pt = 2; m_am = 0; m_at = 2; m_cnt = 0;
      m_up = 0; m_hit = 0; m_arm = 1; e_irq = 0; e_trig = 0;
    end else begin
      emask = m_am | (fbc_en_i ? 'h84 : 0);
      evv = (ev_force_i << 0) | (ev_cursor_i << 1) | (ev_surface_i << 7) |
            (ev_overlay_i << 8) | (ev_manual_i << 11);
      hitnow = (evv & emask) != 0;
      e_trig = hitnow;
      e_irq = 0;
      if (vsync_i) begin
        if (m_up) begin
          m_am = m_pm; m_at = m_pt; m_cnt = 0; m_arm = 1; m_up = 0;
        end else if (m_hit || hitnow) begin
          m_cnt = 0; m_arm = 1;
        end else begin
          nc = (m_cnt < 255) ? m_cnt + 1 : 255;
          if (m_arm && m_at != 0 && nc == m_at) begin e_irq = 1; m_arm = 0; end
          m_cnt = nc;
        end
        m_hit = 0;
      end else if (hitnow) m_hit = 1;
      if (mask_wr_i) begin
        m_pm = MODERN ? (int'(mask_wdata_i) & ~(1 << 8)) : int'(mask_wdata_i);
        m_up = 1;
      end
      if (thr_wr_i) begin
        m_pt = (thr_wdata_i > 255) ? 255 : int'(thr_wdata_i);
        m_up = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (static_irq_o !== e_irq || refresh_trig_o !== e_trig) begin
        fails++;
        $display("FAIL %s model compare: irq/trig act=%0b/%0b exp=%0b/%0b",
                 cur_req, static_irq_o, refresh_trig_o, e_irq, e_trig);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic vsync_pulse();
    @(negedge clk) vsync_i = 1;
    @(negedge clk) vsync_i = 0;
  endtask

  task automatic write_mask(input logic [11:0] v);
    @(negedge clk) begin mask_wr_i = 1; mask_wdata_i = v; end
    @(negedge clk) mask_wr_i = 0;
  endtask

  task automatic write_thr(input logic [15:0] v);
    @(negedge clk) begin thr_wr_i = 1; thr_wdata_i = v; end
    @(negedge clk) thr_wr_i = 0;
  endtask

  // sel: 0 force, 1 cursor, 2 surface, 3 overlay, 4 manual; returns trig seen after
  task automatic pulse_ev(input int sel, output bit trig);
    @(negedge clk) begin
      ev_force_i = (sel == 0); ev_cursor_i = (sel == 1); ev_surface_i = (sel == 2);
      ev_overlay_i = (sel == 3); ev_manual_i = (sel == 4);
    end
    @(negedge clk) begin
      trig = refresh_trig_o;
      ev_force_i = 0; ev_cursor_i = 0; ev_surface_i = 0; ev_overlay_i = 0; ev_manual_i = 0;
    end
  endtask

  task automatic frames_to_irq(input int maxf, input bit noisy, output int n);
    bit t;
    n = 0;
    for (int i = 1; i <= maxf; i++) begin
      if (noisy) pulse_ev(2, t);
      vsync_pulse();
      if (static_irq_o) begin n = i; break; end
      idle(2);
    end
  endtask

  function automatic int thr_for_hz(input int hz);
    int ft;
    ft = 1000000 / hz;
    return (30000 / ft) + 1;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit t;
    idle(3);
    check(static_irq_o === 0 && refresh_trig_o === 0, "R6 outputs low in reset", static_irq_o, 0);
    @(negedge clk) rst = 0;
    idle(2);

    cur_req = "R6";
    frames_to_irq(6, 0, n);
    check(n == 2, "R6 default threshold frames", n, 2);

    cur_req = "R4";
    frames_to_irq(5, 0, n);
    check(n == 0, "R4 no repeat interrupt", n, 0);

    cur_req = "R1";
    write_mask(12'h883);
    vsync_pulse();
    idle(2);
    pulse_ev(0, t); check(t == 1, "R1 force bit0 trigger", t, 1);
    pulse_ev(1, t); check(t == 1, "R1 cursor bit1 trigger", t, 1);
    pulse_ev(2, t); check(t == 1, "R1 surface bit7 trigger", t, 1);
    pulse_ev(4, t); check(t == 1, "R1 manual bit11 trigger", t, 1);
    cur_req = "R3";
    frames_to_irq(6, 0, n);
    check(n == 3, "R3 dirty frame then two clean frames", n, 3);
    cur_req = "R2";
    pulse_ev(2, t); check(t == 1, "R2 trigger after interrupt fired", t, 1);

    cur_req = "R3";
    vsync_pulse();
    idle(2);
    @(negedge clk) begin vsync_i = 1; ev_surface_i = 1; end
    @(negedge clk) begin vsync_i = 0; ev_surface_i = 0; end
    idle(2);
    frames_to_irq(6, 0, n);
    check(n == 2, "R3 event in vsync cycle dirties frame", n, 2);

    cur_req = "R10";
    write_mask(12'h100);
    vsync_pulse();
    idle(2);
    pulse_ev(3, t); check(t == 0, "R10 overlay bit dropped", t, 0);

    cur_req = "R8";
    write_mask(12'h000);
    vsync_pulse();
    idle(2);
    frames_to_irq(6, 1, n);
    check(n == 2, "R8 zero mask ignores events", n, 2);

    cur_req = "R11";
    fbc_en_i = 1;
    pulse_ev(2, t); check(t == 1, "R11 compression adds surface", t, 1);
    write_thr(16'd2);
    vsync_pulse();
    idle(2);
    frames_to_irq(6, 1, n);
    check(n == 0, "R11 surface events keep screen dirty", n, 0);
    @(negedge clk) fbc_en_i = 0;

    cur_req = "R5";
    write_thr(16'd300);
    vsync_pulse();
    idle(2);
    frames_to_irq(300, 0, n);
    check(n == 255, "R5 clamp to 255", n, 255);

    cur_req = "R7";
    write_thr(16'd0);
    vsync_pulse();
    idle(2);
    frames_to_irq(10, 0, n);
    check(n == 0, "R7 zero threshold silent", n, 0);

    cur_req = "R9";
    write_thr(16'd2);
    vsync_pulse();
    idle(2);
    vsync_pulse();
    idle(2);
    write_thr(16'd5);
    vsync_pulse();
    check(static_irq_o == 0, "R9 reload vsync gives no interrupt", static_irq_o, 0);
    idle(2);
    frames_to_irq(8, 0, n);
    check(n == 5, "R9 new threshold after reload", n, 5);

    cur_req = "R12";
    check(thr_for_hz(60) == 2, "R12 60 Hz threshold", thr_for_hz(60), 2);
    check(thr_for_hz(144) == 5, "R12 144 Hz threshold", thr_for_hz(144), 5);
    write_thr(16'(thr_for_hz(60)));
    vsync_pulse();
    idle(2);
    frames_to_irq(8, 0, n);
    check(n == 2, "R12 60 Hz frames", n, 2);
    write_thr(16'(thr_for_hz(144)));
    vsync_pulse();
    idle(2);
    frames_to_irq(8, 0, n);
    check(n == 5, "R12 144 Hz frames", n, 5);

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule